// File: doc/BRIEF.md
# EEPROM Image Cache with Checksum Validation

This block holds a local copy of a 64-word, 16-bit serial EEPROM image and decides whether that copy can be trusted. A load fetches every word in ascending address order through a request/response port to a serial EEPROM master. Each word goes into the local copy as it arrives, and its value is added into a 16-bit accumulator. When the last word is in, the image is judged. The wrapped sum must match a magic constant, and the masked signature field of word 0 must match a fixed valid pattern. If the sum is wrong, word 0 of the local copy is overwritten with a clear value, so the image can never look valid until it is loaded again.

A lookup port returns one word per request and uses a ready/valid handshake. When the cached signature is valid, the word comes straight from the local copy. When it is not, the block first performs a full load and then answers from the fresh copy. If that load fails, or if the index is out of range, the answer is zero. A command port starts an explicit load, writes a single word, or recomputes the checksum. The checksum command sums words 0 to 62 and writes the magic constant minus that sum into word 63. Every write invalidates the cached signature, so the next lookup reloads.

Top module: `eeprom_image_cache`

## Requirements
- R1: A load issues exactly 64 read requests, for addresses 0, 1, ... 63 in that order, with one request outstanding at a time, and stores each returned word at its address in the local copy.
- R2: A load whose 16-bit wrapped word sum is 0xBABA and whose word 0 satisfies (word0 & 0xC000) == 0x4000 sets image_valid and clears both error flags. image_valid is 0 after reset.
- R3: A load whose sum is not 0xBABA sets checksum_error and clears image_valid. It also replaces word 0 of the local copy with 0x0000, so every later lookup triggers another load.
- R4: A load with a correct sum but a failing signature sets signature_error, leaves checksum_error low and image_valid low, and answers lookups with zero. Each later lookup loads again.
- R5: A lookup of index below 64 while the cached signature is valid is answered on rsp_valid in the cycle after the handshake, with the cached word and no EEPROM traffic.
- R6: A lookup while the cached signature is invalid performs a full load first. rsp_valid rises in the cycle after the load's last word is judged.
- R7: A lookup with index 64 or above returns 0 in the cycle after the handshake, with no EEPROM traffic. A lookup answered from a failed load also returns 0.
- R8: Command code 2'b10 reads words 0 to 62 in order and then writes 0xBABA minus their 16-bit sum to word 63.
- R9: Command code 2'b01 writes op_wdata to op_addr. Any write, including the one made by R8, clears image_valid and the cached signature once the master acknowledges it.
- R10: Command code 2'b00 starts a load and 2'b11 is accepted with no effect. When idle, a pending lookup wins over a pending command: op_ready is low while lk_valid is high.
- R11: load_busy is high from the cycle after a load starts until the load is judged. It is low after reset, and lk_ready and op_ready are both low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | 7 | Word index of the lookup (64 and above is out of range) |
| lk_ready | output | 1 | Lookup accepted when high together with lk_valid |
| rsp_valid | output | 1 | One-cycle pulse carrying a lookup answer |
| rsp_word | output | 16 | Lookup answer |
| op_valid | input | 1 | Command request |
| op_code | input | 2 | 00 load, 01 write word, 10 checksum update, 11 no operation |
| op_addr | input | 6 | Word address for a write |
| op_wdata | input | 16 | Data for a write |
| op_ready | output | 1 | Command accepted when high together with op_valid |
| mem_req_valid | output | 1 | Request to the serial EEPROM master |
| mem_req_ready | input | 1 | Master accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 6 | Word address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data or write completion from the master |
| mem_rsp_rdata | input | 16 | Read data |
| load_busy | output | 1 | A load is in progress |
| image_valid | output | 1 | Last load passed both checks and no write followed |
| checksum_error | output | 1 | Last load failed the sum check |
| signature_error | output | 1 | Last load passed the sum check but failed the signature check |

## Verification
Several properties are checked on every cycle. A request to the master holds steady until it is accepted. Read addresses within a load only ever advance by one. No write is issued during a load. The two error flags never coexist, and neither coexists with image_valid. A response given while the image is not valid carries zero. A lookup always wins arbitration, and both ports are closed while a load runs. Other behaviour can only be shown through scenarios: the actual sum and signature decisions, the value written into word 63, lazy reloading after writes and failed loads, and whether a lookup returns cached or fresh data. The bench does this with an EEPROM model whose contents it corrupts and repairs.

// File: rtl/eic_pkg.sv
package eic_pkg;

    // Command codes on op_code
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_WRITE = 2'b01,
        OP_CSUM  = 2'b10,
        OP_NOP   = 2'b11
    } eic_op_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_REQ,
        ST_LD_WAIT,
        ST_LD_CHECK,
        ST_SUM_REQ,
        ST_SUM_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT
    } eic_state_e;

endpackage

// File: rtl/eic_word_store.sv
module eic_word_store #(
    parameter int DATA_W    = 16,
    parameter int WORDS     = 64,
    parameter int SIG_INDEX = 0,
    localparam int AW       = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sig_word
);

    logic [DATA_W-1:0] word_d [WORDS];
    logic [DATA_W-1:0] word_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            word_d[i] = word_q[i];
            if (wr_en && (wr_addr == AW'(i))) begin
                word_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                word_q[i] <= '0;
            end
        end else begin
            word_q <= word_d;
        end
    end

    assign rd_data  = word_q[rd_addr];
    assign sig_word = word_q[SIG_INDEX];

endmodule

// File: rtl/eic_sum_acc.sv
module eic_sum_acc #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] add_val,
    output logic [DATA_W-1:0] sum
);

    logic [DATA_W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (add_en) begin
            sum_d = sum_q + add_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum = sum_q;

endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
    import eic_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter int              WORDS     = 64,
    parameter logic [DATA_W-1:0] MAGIC     = 16'hBABA,
    parameter int              SIG_INDEX = 0,
    parameter logic [DATA_W-1:0] SIG_MASK  = 16'hC000,
    parameter logic [DATA_W-1:0] SIG_VALID = 16'h4000,
    parameter logic [DATA_W-1:0] SIG_CLEAR = 16'h0000,
    localparam int             AW        = $clog2(WORDS),
    localparam int             IDX_W     = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup port
    input  logic              lk_valid,
    input  logic [IDX_W-1:0]  lk_index,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_word,
    // command port
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [AW-1:0]     op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              op_ready,
    // serial master port
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [AW-1:0]     mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    // status
    output logic              load_busy,
    output logic              image_valid,
    output logic              checksum_error,
    output logic              signature_error,
    // word store
    output logic              st_wr_en,
    output logic [AW-1:0]     st_wr_addr,
    output logic [DATA_W-1:0] st_wr_data,
    output logic [AW-1:0]     st_rd_addr,
    input  logic [DATA_W-1:0] st_rd_data,
    input  logic [DATA_W-1:0] st_sig_word,
    // accumulator
    output logic              acc_clr,
    output logic              acc_add,
    output logic [DATA_W-1:0] acc_val,
    input  logic [DATA_W-1:0] acc_sum
);

    localparam logic [AW-1:0]    LAST_ADDR = AW'(WORDS - 1);
    localparam logic [AW-1:0]    SUM_LAST  = AW'(WORDS - 2);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(WORDS);

    typedef struct packed {
        eic_state_e        state;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] wdata;
        logic              lk_pend;
        logic [AW-1:0]     lk_idx;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_word;
        logic              img_ok;
        logic              csum_err;
        logic              sig_err;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic sig_ok;
    logic sum_ok;
    logic [DATA_W-1:0] partial_sum;

    assign sig_ok      = (st_sig_word & SIG_MASK) == SIG_VALID;
    assign sum_ok      = acc_sum == MAGIC;
    assign partial_sum = acc_sum + mem_rsp_rdata;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        st_wr_en      = 1'b0;
        st_wr_addr    = r_q.addr;
        st_wr_data    = mem_rsp_rdata;
        st_rd_addr    = r_q.lk_idx;
        acc_clr       = 1'b0;
        acc_add       = 1'b0;
        acc_val       = mem_rsp_rdata;

        unique case (r_q.state)
            ST_IDLE: begin
                if (lk_valid) begin
                    st_rd_addr = lk_index[AW-1:0];
                    if (lk_index >= IDX_LIMIT) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_word  = '0;
                    end else if (sig_ok) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_word  = st_rd_data;
                    end else begin
                        r_d.lk_pend  = 1'b1;
                        r_d.lk_idx   = lk_index[AW-1:0];
                        r_d.addr     = '0;
                        r_d.img_ok   = 1'b0;
                        r_d.csum_err = 1'b0;
                        r_d.sig_err  = 1'b0;
                        r_d.state    = ST_LD_REQ;
                        acc_clr      = 1'b1;
                    end
                end else if (op_valid) begin
                    unique case (eic_op_e'(op_code))
                        OP_LOAD: begin
                            r_d.lk_pend  = 1'b0;
                            r_d.addr     = '0;
                            r_d.img_ok   = 1'b0;
                            r_d.csum_err = 1'b0;
                            r_d.sig_err  = 1'b0;
                            r_d.state    = ST_LD_REQ;
                            acc_clr      = 1'b1;
                        end
                        OP_WRITE: begin
                            r_d.addr  = op_addr;
                            r_d.wdata = op_wdata;
                            r_d.state = ST_WR_REQ;
                        end
                        OP_CSUM: begin
                            r_d.addr  = '0;
                            r_d.state = ST_SUM_REQ;
                            acc_clr   = 1'b1;
                        end
                        default: begin
                            r_d.state = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_LD_REQ: begin
                if (mem_req_ready) r_d.state = ST_LD_WAIT;
            end
            ST_LD_WAIT: begin
                if (mem_rsp_valid) begin
                    st_wr_en = 1'b1;
                    acc_add  = 1'b1;
                    if (r_q.addr == LAST_ADDR) begin
                        r_d.state = ST_LD_CHECK;
                    end else begin
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.state = ST_LD_REQ;
                    end
                end
            end
            ST_LD_CHECK: begin
                if (!sum_ok) begin
                    st_wr_en     = 1'b1;
                    st_wr_addr   = AW'(SIG_INDEX);
                    st_wr_data   = SIG_CLEAR;
                    r_d.csum_err = 1'b1;
                end else if (!sig_ok) begin
                    r_d.sig_err = 1'b1;
                end else begin
                    r_d.img_ok = 1'b1;
                end
                if (r_q.lk_pend) begin
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_word  = (sum_ok && sig_ok) ? st_rd_data : '0;
                end
                r_d.lk_pend = 1'b0;
                r_d.state   = ST_IDLE;
            end
            ST_SUM_REQ: begin
                if (mem_req_ready) r_d.state = ST_SUM_WAIT;
            end
            ST_SUM_WAIT: begin
                if (mem_rsp_valid) begin
                    acc_add = 1'b1;
                    if (r_q.addr == SUM_LAST) begin
                        r_d.addr  = LAST_ADDR;
                        r_d.wdata = MAGIC - partial_sum;
                        r_d.state = ST_WR_REQ;
                    end else begin
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.state = ST_SUM_REQ;
                    end
                end
            end
            ST_WR_REQ: begin
                if (mem_req_ready) r_d.state = ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                if (mem_rsp_valid) begin
                    st_wr_en   = 1'b1;
                    st_wr_addr = AW'(SIG_INDEX);
                    st_wr_data = SIG_CLEAR;
                    r_d.img_ok = 1'b0;
                    r_d.state  = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign lk_ready      = r_q.state == ST_IDLE;
    assign op_ready      = (r_q.state == ST_IDLE) && !lk_valid;
    assign rsp_valid     = r_q.rsp_valid;
    assign rsp_word      = r_q.rsp_word;
    assign mem_req_valid = (r_q.state == ST_LD_REQ) || (r_q.state == ST_SUM_REQ) ||
                           (r_q.state == ST_WR_REQ);
    assign mem_req_write = r_q.state == ST_WR_REQ;
    assign mem_req_addr  = r_q.addr;
    assign mem_req_wdata = r_q.wdata;
    assign load_busy     = (r_q.state == ST_LD_REQ) || (r_q.state == ST_LD_WAIT) ||
                           (r_q.state == ST_LD_CHECK);
    assign image_valid     = r_q.img_ok;
    assign checksum_error  = r_q.csum_err;
    assign signature_error = r_q.sig_err;

endmodule

// File: rtl/eeprom_image_cache.sv
module eeprom_image_cache #(
    parameter int                DATA_W    = 16,
    parameter int                WORDS     = 64,
    parameter logic [DATA_W-1:0] MAGIC     = 16'hBABA,
    parameter int                SIG_INDEX = 0,
    parameter logic [DATA_W-1:0] SIG_MASK  = 16'hC000,
    parameter logic [DATA_W-1:0] SIG_VALID = 16'h4000,
    parameter logic [DATA_W-1:0] SIG_CLEAR = 16'h0000,
    localparam int               AW        = $clog2(WORDS),
    localparam int               IDX_W     = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [IDX_W-1:0]  lk_index,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_word,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [AW-1:0]     op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              op_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [AW-1:0]     mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              load_busy,
    output logic              image_valid,
    output logic              checksum_error,
    output logic              signature_error
);

    logic              st_wr_en;
    logic [AW-1:0]     st_wr_addr;
    logic [DATA_W-1:0] st_wr_data;
    logic [AW-1:0]     st_rd_addr;
    logic [DATA_W-1:0] st_rd_data;
    logic [DATA_W-1:0] st_sig_word;
    logic              acc_clr;
    logic              acc_add;
    logic [DATA_W-1:0] acc_val;
    logic [DATA_W-1:0] acc_sum;

    eic_word_store #(
        .DATA_W(DATA_W), .WORDS(WORDS), .SIG_INDEX(SIG_INDEX)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_wr_en),
        .wr_addr  (st_wr_addr),
        .wr_data  (st_wr_data),
        .rd_addr  (st_rd_addr),
        .rd_data  (st_rd_data),
        .sig_word (st_sig_word)
    );

    eic_sum_acc #(.DATA_W(DATA_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .add_en  (acc_add),
        .add_val (acc_val),
        .sum     (acc_sum)
    );

    eic_ctrl #(
        .DATA_W(DATA_W), .WORDS(WORDS), .MAGIC(MAGIC), .SIG_INDEX(SIG_INDEX),
        .SIG_MASK(SIG_MASK), .SIG_VALID(SIG_VALID), .SIG_CLEAR(SIG_CLEAR)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .lk_valid        (lk_valid),
        .lk_index        (lk_index),
        .lk_ready        (lk_ready),
        .rsp_valid       (rsp_valid),
        .rsp_word        (rsp_word),
        .op_valid        (op_valid),
        .op_code         (op_code),
        .op_addr         (op_addr),
        .op_wdata        (op_wdata),
        .op_ready        (op_ready),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_req_write   (mem_req_write),
        .mem_req_addr    (mem_req_addr),
        .mem_req_wdata   (mem_req_wdata),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_rdata   (mem_rsp_rdata),
        .load_busy       (load_busy),
        .image_valid     (image_valid),
        .checksum_error  (checksum_error),
        .signature_error (signature_error),
        .st_wr_en        (st_wr_en),
        .st_wr_addr      (st_wr_addr),
        .st_wr_data      (st_wr_data),
        .st_rd_addr      (st_rd_addr),
        .st_rd_data      (st_rd_data),
        .st_sig_word     (st_sig_word),
        .acc_clr         (acc_clr),
        .acc_add         (acc_add),
        .acc_val         (acc_val),
        .acc_sum         (acc_sum)
    );

endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
    parameter int DATA_W = 16,
    parameter int AW     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_ready,
    input logic              op_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_word,
    input logic              image_valid,
    input logic              checksum_error,
    input logic              signature_error,
    input logic              load_busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [AW-1:0]     mem_req_addr
);

    logic [AW-1:0] prev_rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rd_q <= '0;
        end else if (mem_req_valid && mem_req_ready && !mem_req_write) begin
            prev_rd_q <= mem_req_addr;
        end
    end

    // R1: a request is held until the master takes it
    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R1: within a load, read addresses step by exactly one
    assert_load_ascend_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !mem_req_write && load_busy && mem_req_addr != '0)
        |-> mem_req_addr == prev_rd_q + 1'b1);

    // R2: a valid image carries no error flag
    assert_valid_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        image_valid |-> !checksum_error && !signature_error);

    // R4: the two error flags are exclusive
    assert_err_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(checksum_error && signature_error));

    // R7: an answer given without a valid image is zero
    assert_zero_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !image_valid |-> rsp_word == '0);

    // R9: no write is issued while a load runs
    assert_no_write_in_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> !load_busy);

    // R10: a lookup wins arbitration
    assert_lookup_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> !op_ready);

    // R11: both ports closed while loading
    assert_busy_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy |-> !lk_ready && !op_ready);

endmodule

bind eeprom_image_cache eic_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .lk_valid        (lk_valid),
    .lk_ready        (lk_ready),
    .op_ready        (op_ready),
    .rsp_valid       (rsp_valid),
    .rsp_word        (rsp_word),
    .image_valid     (image_valid),
    .checksum_error  (checksum_error),
    .signature_error (signature_error),
    .load_busy       (load_busy),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_write   (mem_req_write),
    .mem_req_addr    (mem_req_addr)
);

// File: tb/eeprom_image_cache_test.sv
module eeprom_image_cache_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [6:0]  lk_index = '0;
    logic        lk_ready;
    logic        rsp_valid;
    logic [15:0] rsp_word;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic [5:0]  op_addr = '0;
    logic [15:0] op_wdata = '0;
    logic        op_ready;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [5:0]  mem_req_addr;
    logic [15:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [15:0] mem_rsp_rdata;
    logic        load_busy;
    logic        image_valid;
    logic        checksum_error;
    logic        signature_error;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_image_cache uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_index(lk_index), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
        .op_wdata(op_wdata), .op_ready(op_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata),
        .load_busy(load_busy), .image_valid(image_valid),
        .checksum_error(checksum_error), .signature_error(signature_error)
    );

    int checks = 0;
    int failures = 0;

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [64];
    logic        m_busy;
    int          m_cnt;
    logic        m_rsp;
    logic [15:0] m_rdata;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          last_wr_addr = -1;
    int          trace [2048];

    assign mem_req_ready = !m_busy;
    assign mem_rsp_valid = m_rsp;
    assign mem_rsp_rdata = m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_rsp  <= 1'b0;
            m_cnt  <= 0;
            m_rdata <= '0;
        end else begin
            m_rsp <= 1'b0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_rsp  <= 1'b1;
                    m_busy <= 1'b0;
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end else if (mem_req_valid) begin
                m_busy <= 1'b1;
                m_cnt  <= 1;
                if (mem_req_write) begin
                    mem[mem_req_addr] <= mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                    last_wr_addr <= int'(mem_req_addr);
                end else begin
                    m_rdata <= mem[mem_req_addr];
                    if (rd_cnt < 2048) trace[rd_cnt] <= int'(mem_req_addr);
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_q [$];

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R5 unexpected answer actual=%0h expected=none", rsp_word);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (rsp_word !== e) begin
                    failures++;
                    $display("FAIL R5/R6/R7 answer actual=%0h expected=%0h", rsp_word, e);
                end
            end
        end
    end

    // ---------------- reference helpers ----------------
    bit bench_valid = 1'b0;

    function automatic logic [15:0] sum_words(int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    function automatic bit load_ok();
        return (sum_words(64) == 16'hBABA) && ((mem[0] & 16'hC000) == 16'h4000);
    endfunction

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while ((!lk_ready || exp_q.size() != 0) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic check_order(int base, int n, string tag);
        bit ok = 1'b1;
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (trace[base + i] != i) begin
                ok = 1'b0;
                bad = i;
                break;
            end
        end
        check_eq(tag, ok ? 32'd0 : 32'(trace[base + bad]), ok ? 32'd0 : 32'(bad));
    endtask

    // lookup driver: computes the expected answer and reload behaviour
    task automatic do_lookup(int idx);
        int   base = rd_cnt;
        bit   miss;
        bit   ok;
        logic [15:0] e;
        miss = (idx < 64) && !bench_valid;
        if (idx >= 64) begin
            e = '0;
        end else if (bench_valid) begin
            e = mem[idx];
        end else begin
            ok = load_ok();
            e = ok ? mem[idx] : 16'h0000;
            bench_valid = ok;
        end
        exp_q.push_back(e);
        lk_index = 7'(idx);
        lk_valid = 1'b1;
        while (!lk_ready) @(negedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        if (miss) check_eq("R11 load_busy during reload", 32'(load_busy), 32'd1);
        wait_idle();
        if (miss) begin
            check_eq("R6 reload read count", 32'(rd_cnt - base), 32'd64);
            check_order(base, 64, "R1 load read order");
        end else begin
            check_eq("R5/R7 no traffic on lookup", 32'(rd_cnt - base), 32'd0);
        end
    endtask

    task automatic do_op(logic [1:0] code, logic [5:0] a, logic [15:0] d);
        op_code  = code;
        op_addr  = a;
        op_wdata = d;
        op_valid = 1'b1;
        while (!op_ready) @(negedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        wait_idle();
        if (code == 2'b01 || code == 2'b10) bench_valid = 1'b0;
        if (code == 2'b00) bench_valid = load_ok();
    endtask

    task automatic csum_update();
        logic [15:0] e = 16'hBABA - sum_words(63);
        int rb = rd_cnt;
        int wb = wr_cnt;
        do_op(2'b10, '0, '0);
        check_eq("R8 update reads", 32'(rd_cnt - rb), 32'd63);
        check_order(rb, 63, "R8 update read order");
        check_eq("R8 update writes", 32'(wr_cnt - wb), 32'd1);
        check_eq("R8 update target", 32'(last_wr_addr), 32'd63);
        check_eq("R8 word63 value", 32'(mem[63]), 32'(e));
        check_eq("R9 update invalidates", 32'(image_valid), 32'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0137 + 16'h0011);
        mem[0] = 16'h4A5C;
        mem[63] = 16'hBABA - sum_words(63);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check_eq("R2 reset image_valid", 32'(image_valid), 32'd0);
        check_eq("R11 reset load_busy", 32'(load_busy), 32'd0);
        check_eq("R3 reset checksum_error", 32'(checksum_error), 32'd0);
        check_eq("R4 reset signature_error", 32'(signature_error), 32'd0);
        check_eq("R10 reset op_ready", 32'(op_ready), 32'd1);

        // first lookup forces a good load
        do_lookup(5);
        check_eq("R2 image_valid after good load", 32'(image_valid), 32'd1);
        check_eq("R2 checksum_error clear", 32'(checksum_error), 32'd0);

        // cached hits
        do_lookup(10);
        do_lookup(63);
        do_lookup(0);

        // out of range
        do_lookup(64);
        do_lookup(127);

        // single write corrupts sum
        begin
            int wb = wr_cnt;
            do_op(2'b01, 6'd7, 16'h1234);
            check_eq("R9 write issued", 32'(wr_cnt - wb), 32'd1);
            check_eq("R9 write target", 32'(last_wr_addr), 32'd7);
            check_eq("R9 write clears image_valid", 32'(image_valid), 32'd0);
        end
        do_lookup(7);
        check_eq("R3 checksum_error set", 32'(checksum_error), 32'd1);
        check_eq("R3 image_valid low", 32'(image_valid), 32'd0);
        do_lookup(0);   // R3: reload again, answer zero

        // repair and explicit load
        csum_update();
        do_op(2'b00, '0, '0);
        check_eq("R2 explicit load valid", 32'(image_valid), 32'd1);
        check_eq("R3 checksum_error cleared", 32'(checksum_error), 32'd0);
        do_lookup(7);

        // bad signature with good sum
        do_op(2'b01, 6'd0, 16'h8123);
        csum_update();
        do_lookup(3);
        check_eq("R4 signature_error set", 32'(signature_error), 32'd1);
        check_eq("R4 checksum_error low", 32'(checksum_error), 32'd0);
        check_eq("R4 image_valid low", 32'(image_valid), 32'd0);
        do_lookup(3);   // R4: loads again

        // restore signature
        do_op(2'b01, 6'd0, 16'h4321);
        csum_update();
        do_op(2'b00, '0, '0);
        check_eq("R2 restored valid", 32'(image_valid), 32'd1);
        check_eq("R4 signature_error cleared", 32'(signature_error), 32'd0);

        // priority: lookup and command together
        begin
            int rb, wb;
            exp_q.push_back(mem[10]);
            lk_index = 7'd10;
            lk_valid = 1'b1;
            op_code  = 2'b11;
            op_valid = 1'b1;
            #1;
            check_eq("R10 op_ready low beside lookup", 32'(op_ready), 32'd0);
            @(negedge clk);
            lk_valid = 1'b0;
            #1;
            check_eq("R10 op_ready after lookup", 32'(op_ready), 32'd1);
            rb = rd_cnt;
            wb = wr_cnt;
            @(negedge clk);
            op_valid = 1'b0;
            wait_idle();
            check_eq("R10 nop no reads", 32'(rd_cnt - rb), 32'd0);
            check_eq("R10 nop no writes", 32'(wr_cnt - wb), 32'd0);
            check_eq("R10 nop keeps image_valid", 32'(image_valid), 32'd1);
        end

        repeat (5) @(negedge clk);
        check_eq("R5 no stray answers", 32'(exp_q.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule